// File: doc/BRIEF.md
# Static Memory Read Strobe Generator

This block runs read cycles on an external asynchronous static memory. On the system side, a request carries a 24-bit address. The block then drives the address, an active-low read strobe and an active-low chip select. It captures one byte from the memory data bus and returns that byte with a one-cycle valid pulse. An acknowledge marks the last cycle of each read.

Each of the two strobes has its own setup and pulse length, counted in clock cycles. Both strobes share one total cycle length. Hold time is not a setting. It is whatever remains of the cycle after setup and pulse. A select input chooses which strobe times the data capture: data is taken on the edge at which that strobe goes high.

The timing settings are sampled when a request is accepted. A new request can be accepted in the acknowledge cycle. With zero setup and zero hold, this lets back-to-back reads keep both strobes low without a gap.

Top module: `smc_rd_strobe`

## Requirements
- R1: During and right after reset, `mem_rd_no` and `mem_cs_no` are high, `ack_o` and `rvalid_o` are low, and `rdata_o` and `mem_addr_o` are zero.
- R2: Number the cycles of a read from 0, where cycle 0 is the one that follows the accepting clock edge. `mem_rd_no` is low exactly in the cycles from `rd_setup_i` up to, but not including, `rd_setup_i + rd_pulse_i`.
- R3: `mem_cs_no` is low exactly in the cycles from `cs_setup_i` up to, but not including, `cs_setup_i + cs_pulse_i`. This timing does not depend on the read strobe.
- R4: Let L be the largest of `cycle_len_i`, `rd_setup_i + rd_pulse_i` and `cs_setup_i + cs_pulse_i`. A read lasts L cycles, so each strobe's hold is L minus its setup and pulse. `ack_o` is high in cycle L-1 only.
- R5: A pulse setting of zero acts as a pulse of one cycle, for both strobes.
- R6: Let S and P be the setup and pulse of the controlling strobe. `rdata_o` takes `mem_data_i` on the clock edge that ends cycle S+P-1, which is the edge where that strobe goes high. The controlling strobe is the read strobe when `ctrl_sel_i` = 0 and the chip select when `ctrl_sel_i` = 1.
- R7: `rvalid_o` is high for exactly the one cycle that follows a capture edge, and `rdata_o` holds the captured byte during that cycle.
- R8: `mem_addr_o` shows the accepted address from cycle 0 through cycle L-1. It keeps that value until the next acceptance.
- R9: When both setups are zero and both holds are zero, a request held high keeps `mem_rd_no` and `mem_cs_no` low continuously across consecutive reads.
- R10: A request is accepted only when no read is running, or in the `ack_o` cycle. At any other time it is ignored. Both strobes are high whenever no read is running.
- R11: All timing and select inputs are sampled at acceptance. Changing them during a read does not alter that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_setup_i | input | TIME_W | Read strobe setup cycles |
| rd_pulse_i | input | TIME_W | Read strobe pulse cycles (0 acts as 1) |
| cs_setup_i | input | TIME_W | Chip select setup cycles |
| cs_pulse_i | input | TIME_W | Chip select pulse cycles (0 acts as 1) |
| cycle_len_i | input | TIME_W+1 | Total read cycle length |
| ctrl_sel_i | input | 1 | Capture strobe: 0 read strobe, 1 chip select |
| req_i | input | 1 | Read request |
| addr_i | input | ADDR_W | Read address |
| ack_o | output | 1 | Last cycle of the current read |
| rvalid_o | output | 1 | Captured byte valid |
| rdata_o | output | DATA_W | Captured byte |
| mem_addr_o | output | ADDR_W | Memory address bus |
| mem_rd_no | output | 1 | Read strobe, active low |
| mem_cs_no | output | 1 | Chip select, active low |
| mem_data_i | input | DATA_W | Memory data bus |

## Verification
Suppose the cycle counter, the stored cycle length or the stored timing copy goes wrong. The fault then shows at the ports within the same read. A strobe edge moves by a cycle, `ack_o` arrives early or late, or the captured byte is the value from the wrong cycle. Because `mem_data_i` changes every cycle, a capture that is off by one edge is seen at the next `rvalid_o`. An acceptance that is missed or extra either shifts every following strobe edge or leaves a strobe low while the block should be idle. The bench compares all outputs every cycle against a cycle model, so it sees such a shift on the first cycle it appears.

// File: rtl/smc_rd_pkg.sv
package smc_rd_pkg;
  typedef enum logic {
    CTRL_RD = 1'b0,
    CTRL_CS = 1'b1
  } ctrl_sel_e;

  localparam int unsigned N_STROBE = 2;
endpackage

// File: rtl/smc_rd_strobe_win.sv
module smc_rd_strobe_win #(
  parameter int unsigned CW = 5
) (
  input  logic [CW-1:0] setup_i,
  input  logic [CW-1:0] pulse_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          act_i,
  output logic          on_o
);
  logic [CW-1:0] stop;
  assign stop = setup_i + pulse_i;
  assign on_o = act_i && (cnt_i >= setup_i) && (cnt_i < stop);
endmodule

// File: rtl/smc_rd_len_calc.sv
module smc_rd_len_calc #(
  parameter int unsigned CW = 5
) (
  input  logic [CW-1:0] rd_sum_i,
  input  logic [CW-1:0] cs_sum_i,
  input  logic [CW-1:0] cycle_i,
  output logic [CW-1:0] len_o
);
  logic [CW-1:0] sum_max;
  always_comb begin
    sum_max = (rd_sum_i > cs_sum_i) ? rd_sum_i : cs_sum_i;
    // hold may not go negative: stretch the cycle to cover both strobes
    len_o   = (cycle_i > sum_max) ? cycle_i : sum_max;
  end
endmodule

// File: rtl/smc_rd_strobe.sv
module smc_rd_strobe
  import smc_rd_pkg::*;
#(
  parameter int unsigned TIME_W = 4,
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] rd_setup_i,
  input  logic [TIME_W-1:0] rd_pulse_i,
  input  logic [TIME_W-1:0] cs_setup_i,
  input  logic [TIME_W-1:0] cs_pulse_i,
  input  logic [TIME_W:0]   cycle_len_i,
  input  logic              ctrl_sel_i,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ack_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_no,
  output logic              mem_cs_no,
  input  logic [DATA_W-1:0] mem_data_i
);
  localparam int unsigned CW = TIME_W + 1;

  typedef struct packed {
    logic [CW-1:0] setup;
    logic [CW-1:0] pulse;
  } win_t;

  win_t          win_in [N_STROBE];
  win_t          win_q  [N_STROBE];
  win_t          win_d  [N_STROBE];
  logic [CW-1:0] len_in, len_q, len_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  ctrl_sel_e     sel_q, sel_d;
  logic [N_STROBE-1:0] on_d;
  logic          done, accept, capture;
  logic [CW-1:0] cap_end;

  // index 0: read strobe, index 1: chip select; pulse 0 acts as 1
  always_comb begin
    win_in[0].setup = {1'b0, rd_setup_i};
    win_in[0].pulse = (rd_pulse_i == '0) ? CW'(1) : {1'b0, rd_pulse_i};
    win_in[1].setup = {1'b0, cs_setup_i};
    win_in[1].pulse = (cs_pulse_i == '0) ? CW'(1) : {1'b0, cs_pulse_i};
  end

  smc_rd_len_calc #(.CW(CW)) u_len (
    .rd_sum_i (win_in[0].setup + win_in[0].pulse),
    .cs_sum_i (win_in[1].setup + win_in[1].pulse),
    .cycle_i  (cycle_len_i),
    .len_o    (len_in)
  );

  assign done    = busy_q && (cnt_q == len_q - CW'(1));
  assign accept  = req_i && (!busy_q || done);
  assign cap_end = win_q[sel_q].setup + win_q[sel_q].pulse - CW'(1);
  assign capture = busy_q && (cnt_q == cap_end);
  assign ack_o   = done;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    len_d  = len_q;
    sel_d  = sel_q;
    win_d  = win_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      len_d  = len_in;
      sel_d  = ctrl_sel_e'(ctrl_sel_i);
      win_d  = win_in;
    end else if (done) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d  = cnt_q + CW'(1);
    end
  end

  // strobes registered from next state: glitch-free, same cycle alignment
  for (genvar g = 0; g < N_STROBE; g++) begin : g_strobe
    smc_rd_strobe_win #(.CW(CW)) u_win (
      .setup_i (win_d[g].setup),
      .pulse_i (win_d[g].pulse),
      .cnt_i   (cnt_d),
      .act_i   (busy_d),
      .on_o    (on_d[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      len_q      <= CW'(1);
      sel_q      <= CTRL_RD;
      for (int i = 0; i < N_STROBE; i++) win_q[i] <= '{setup: '0, pulse: CW'(1)};
      mem_rd_no  <= 1'b1;
      mem_cs_no  <= 1'b1;
      mem_addr_o <= '0;
      rdata_o    <= '0;
      rvalid_o   <= 1'b0;
    end else begin
      busy_q     <= busy_d;
      cnt_q      <= cnt_d;
      len_q      <= len_d;
      sel_q      <= sel_d;
      win_q      <= win_d;
      mem_rd_no  <= ~on_d[0];
      mem_cs_no  <= ~on_d[1];
      if (accept) mem_addr_o <= addr_i;
      if (capture) rdata_o <= mem_data_i;
      rvalid_o   <= capture;
    end
  end

  a_r10_idle_strobes_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (mem_rd_no && mem_cs_no));

  a_r8_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !accept) |=> $stable(mem_addr_o));

  a_r4_cnt_in_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q < len_q));

  a_r5_pulse_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (win_q[0].pulse != '0 && win_q[1].pulse != '0));

  a_r7_rvalid_from_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(busy_q));
endmodule

// File: tb/smc_rd_strobe_bench.sv
module smc_rd_strobe_bench;
  localparam int TIME_W = 4;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [TIME_W-1:0] rd_setup = '0, rd_pulse = '0, cs_setup = '0, cs_pulse = '0;
  logic [TIME_W:0]   cycle_len = '0;
  logic              ctrl_sel = 1'b0, req = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] mem_data = '0;
  logic              ack, rvalid, mem_rd_n, mem_cs_n;
  logic [DATA_W-1:0] rdata;
  logic [ADDR_W-1:0] mem_addr;

  int vectors = 0, fails = 0;
  string phase = "R1";

  // reference model state
  int m_busy, m_cnt, m_len, m_sel, m_rs, m_rp, m_cs, m_cp, m_addr, m_rdata, m_rvalid;

  always #2 clk = ~clk;

  smc_rd_strobe #(.TIME_W(TIME_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_smc_rd_strobe (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_setup_i(rd_setup), .rd_pulse_i(rd_pulse),
    .cs_setup_i(cs_setup), .cs_pulse_i(cs_pulse),
    .cycle_len_i(cycle_len), .ctrl_sel_i(ctrl_sel),
    .req_i(req), .addr_i(addr),
    .ack_o(ack), .rvalid_o(rvalid), .rdata_o(rdata),
    .mem_addr_o(mem_addr), .mem_rd_no(mem_rd_n), .mem_cs_no(mem_cs_n),
    .mem_data_i(mem_data)
  );

  function automatic int umax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int fix_pulse(int p);
    return (p == 0) ? 1 : p;  // R5
  endfunction

  task automatic chk(bit ok, string rq, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] t=%0t actual=%0d expected=%0d", rq, phase, $time, act, exp);
    end
  endtask

  task automatic model_reset();
    m_busy = 0; m_cnt = 0; m_len = 1; m_sel = 0;
    m_rs = 0; m_rp = 1; m_cs = 0; m_cp = 1;
    m_addr = 0; m_rdata = 0; m_rvalid = 0;
  endtask

  task automatic check_outputs();
    int e_rd, e_cs, e_ack;
    e_rd  = (m_busy != 0 && m_cnt >= m_rs && m_cnt < m_rs + m_rp) ? 0 : 1;
    e_cs  = (m_busy != 0 && m_cnt >= m_cs && m_cnt < m_cs + m_cp) ? 0 : 1;
    e_ack = (m_busy != 0 && m_cnt == m_len - 1) ? 1 : 0;
    chk(int'(mem_rd_n) == e_rd, "R2", int'(mem_rd_n), e_rd);
    chk(int'(mem_cs_n) == e_cs, "R3", int'(mem_cs_n), e_cs);
    chk(int'(ack) == e_ack, "R4", int'(ack), e_ack);
    chk(int'(rvalid) == m_rvalid, "R7", int'(rvalid), m_rvalid);
    if (m_rvalid != 0) chk(int'(rdata) == m_rdata, "R6", int'(rdata), m_rdata);
    chk(int'(mem_addr) == m_addr, "R8", int'(mem_addr), m_addr);
  endtask

  // advance model by one clock edge using the inputs held since the negedge
  task automatic model_step();
    int done, cap_end;
    done    = (m_busy != 0 && m_cnt == m_len - 1) ? 1 : 0;
    cap_end = (m_sel != 0) ? m_cs + m_cp - 1 : m_rs + m_rp - 1;
    m_rvalid = (m_busy != 0 && m_cnt == cap_end) ? 1 : 0;
    if (m_rvalid != 0) m_rdata = int'(mem_data);
    if (req && (m_busy == 0 || done != 0)) begin  // R10 acceptance rule, R11 sampling
      m_busy = 1; m_cnt = 0;
      m_rs = int'(rd_setup); m_rp = fix_pulse(int'(rd_pulse));
      m_cs = int'(cs_setup); m_cp = fix_pulse(int'(cs_pulse));
      m_len = umax(int'(cycle_len), umax(m_rs + m_rp, m_cs + m_cp));
      m_sel = int'(ctrl_sel);
      m_addr = int'(addr);
    end else if (done != 0) begin
      m_busy = 0; m_cnt = 0;
    end else if (m_busy != 0) begin
      m_cnt++;
    end
  endtask

  task automatic rand_cfg(int smax, int pmin, int pmax, int cmax);
    rd_setup  = TIME_W'($urandom_range(smax, 0));
    cs_setup  = TIME_W'($urandom_range(smax, 0));
    rd_pulse  = TIME_W'($urandom_range(pmax, pmin));
    cs_pulse  = TIME_W'($urandom_range(pmax, pmin));
    cycle_len = (TIME_W+1)'($urandom_range(cmax, 0));
    ctrl_sel  = 1'($urandom_range(1, 0));
  endtask

  task automatic run_phase(string tag, int n);
    phase = tag;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_outputs();
      mem_data = DATA_W'($urandom);
      case (tag)
        "R2": begin  // general random, config drawn with each request
          req = ($urandom_range(3, 0) == 0);
          if (req) begin rand_cfg(5, 0, 5, 15); addr = ADDR_W'($urandom); end
        end
        "R5": begin  // zero pulses
          req = ($urandom_range(2, 0) == 0);
          if (req) begin
            rand_cfg(4, 0, 0, 6);
            addr = ADDR_W'($urandom);
          end
        end
        "R9": begin  // zero setup, zero hold, request held high
          req = 1'b1;
          rd_setup = '0; cs_setup = '0;
          rd_pulse = TIME_W'(3); cs_pulse = TIME_W'(3);
          cycle_len = '0;
          ctrl_sel = 1'($urandom_range(1, 0));
          addr = ADDR_W'($urandom);
        end
        "R10": begin  // request always high: only done cycles accept
          req = 1'b1;
          rand_cfg(4, 1, 4, 12);
          addr = ADDR_W'($urandom);
        end
        "R11": begin  // config churns every cycle during reads
          req = ($urandom_range(3, 0) == 0);
          rand_cfg(5, 0, 5, 15);
          addr = ADDR_W'($urandom);
        end
        default: begin  // "R4": cycle length shorter than setup+pulse
          req = ($urandom_range(2, 0) == 0);
          rand_cfg(6, 1, 6, 3);
          addr = ADDR_W'($urandom);
        end
      endcase
      @(posedge clk);
      model_step();
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    phase = "R1";
    check_outputs();
    chk(rdata == '0, "R1", int'(rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs();
    run_phase("R2", 1500);
    run_phase("R5", 1000);
    run_phase("R9", 600);
    run_phase("R10", 1000);
    run_phase("R11", 1500);
    run_phase("R4", 1000);
    @(negedge clk);
    req = 1'b0;
    check_outputs();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule